// File: doc/BRIEF.md
# General-purpose I/O port with SPI and compare-output pin takeover

An eight-pin general-purpose I/O port. Software sets a direction register and a port-output register. Each pin's pad input is sampled through a two-flop synchronizer. An override stage sits between these registers and the pad drivers. It lets a serial peripheral interface (SPI) controller and three timer compare units take over specific pins.

When SPI runs as master, the data-in pin is made an input by force. Its three neighbours keep the direction software gave them and carry the master's data and clock. When SPI runs as slave, the roles swap: the data-out, clock and select pins are forced to inputs, and the data-in pin follows software and carries the slave's data. A pin that the override forces to input still gets its pull-up from the port-output bit. The block also returns the synchronized serial data input, the serial clock input and an active-low select level to the SPI controller. All pad controls are registered.

Top module: `gpio_spi_port`

## Requirements
- R1: With `spi_en` low and every `oc_en` bit low, each pin's `pad_oe` equals its direction bit and `pad_do` equals its port-output bit.
- R2: In master mode (`spi_en`=1, `spi_master`=1), pin 3 has `pad_oe`=0 whatever its direction bit. Pins 0, 1 and 2 take `pad_oe` from their direction bits. Pin 2 drives `spi_mosi_out`, pin 1 drives `spi_sck_out`, and pin 0 drives its port-output bit.
- R3: In slave mode (`spi_en`=1, `spi_master`=0), pins 0, 1 and 2 have `pad_oe`=0 whatever their direction bits. Pin 3 takes `pad_oe` from its direction bit and drives `spi_miso_out`.
- R4: `pad_pue[i]` is 1 exactly when the pin's effective `pad_oe` is 0, its port-output bit is 1 and `pud` is 0. This includes pins forced to input by the SPI override.
- R5: While `pud` is 1, every `pad_pue` bit is 0.
- R6: Pins 4, 5 and 6 belong to compare index 0, 1 and 2. A pin drives `oc_val[k]` when `oc_en[k]` is 1 and drives its port-output bit otherwise. Its `pad_oe` stays equal to its direction bit in both cases.
- R7: `pin_val` equals `pad_in` as it was two rising edges earlier.
- R8: `spi_sdi` is `pin_val[3]` in master mode and `pin_val[2]` otherwise. `spi_sck_in` is `pin_val[1]`.
- R9: `spi_ss_n` equals `pin_val[0]` in slave mode and is 1 in every other mode.
- R10: A synchronous reset clears the direction and port-output registers, the synchronizer and all pad controls.
- R11: A register write presented before edge N shows on the pad controls after edge N+1. A change of a mode, compare or `pud` input shows one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_we | input | 1 | Write strobe for the direction register |
| dir_wdata | input | 8 | Direction value, 1 = output |
| out_we | input | 1 | Write strobe for the port-output register |
| out_wdata | input | 8 | Port-output value |
| pud | input | 1 | Global pull-up disable |
| spi_en | input | 1 | SPI enabled |
| spi_master | input | 1 | 1 = master, 0 = slave |
| spi_mosi_out | input | 1 | Master serial data out |
| spi_miso_out | input | 1 | Slave serial data out |
| spi_sck_out | input | 1 | Master serial clock out |
| oc_en | input | 3 | Compare-output enables for pins 4..6 |
| oc_val | input | 3 | Compare-output levels for pins 4..6 |
| pad_in | input | 8 | Raw pad input levels |
| pad_oe | output | 8 | Pad output enable |
| pad_do | output | 8 | Pad output value |
| pad_pue | output | 8 | Pad pull-up enable |
| pin_val | output | 8 | Synchronized pin levels |
| spi_sdi | output | 1 | Serial data into the SPI controller |
| spi_sck_in | output | 1 | Serial clock into the SPI controller |
| spi_ss_n | output | 1 | Active-low select level for the SPI slave |

## Verification
The bench drives the same direction and port-output patterns (all ones, all zeros, alternating bits) through the three modes: plain GPIO, master and slave. A pin's direction then comes from software in one mode and is forced in another, so a swapped or missing override shows at once. Pull-up checks pair an all-ones port value with mixed directions, with and without `pud`. This separates "pull-up follows the forced direction" from "pull-up follows the direction register". Compare-output checks use opposite `oc_val` and port values, so the selected source is visible. The latency checks sample one edge early and then on time, to pin down the synchronizer depth and the output register.

// File: rtl/gpio_spi_pkg.sv
package gpio_spi_pkg;
  localparam int PIN_SEL  = 0;
  localparam int PIN_SCK  = 1;
  localparam int PIN_SDO  = 2;
  localparam int PIN_SDI  = 3;
  localparam int PIN_OC0  = 4;
  localparam int NUM_OC   = 3;

  typedef enum logic [1:0] {
    MODE_GPIO   = 2'd0,
    MODE_MASTER = 2'd1,
    MODE_SLAVE  = 2'd2
  } spi_mode_e;

  function automatic spi_mode_e decode_mode(input logic en, input logic master);
    if (!en)        return MODE_GPIO;
    else if (master) return MODE_MASTER;
    else            return MODE_SLAVE;
  endfunction
endpackage

// File: rtl/pad_sync.sv
module pad_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/port_regs.sv
module port_regs #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dir_we,
  input  logic [WIDTH-1:0] dir_wdata,
  input  logic             out_we,
  input  logic [WIDTH-1:0] out_wdata,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] out_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
      out_q <= '0;
    end else begin
      if (dir_we) dir_q <= dir_wdata;
      if (out_we) out_q <= out_wdata;
    end
  end
endmodule

// File: rtl/pin_override.sv
module pin_override
  import gpio_spi_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  spi_mode_e        mode,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] out_q,
  input  logic             pud,
  input  logic             mosi_out,
  input  logic             miso_out,
  input  logic             sck_out,
  input  logic [NUM_OC-1:0] oc_en,
  input  logic [NUM_OC-1:0] oc_val,
  output logic [WIDTH-1:0] oe,
  output logic [WIDTH-1:0] dout,
  output logic [WIDTH-1:0] pue
);
  always_comb begin
    oe   = dir_q;
    dout = out_q;
    for (int k = 0; k < NUM_OC; k++) begin
      if (oc_en[k]) dout[PIN_OC0+k] = oc_val[k];
    end
    case (mode)
      MODE_MASTER: begin
        oe[PIN_SDI]   = 1'b0;
        dout[PIN_SDO] = mosi_out;
        dout[PIN_SCK] = sck_out;
      end
      MODE_SLAVE: begin
        oe[PIN_SEL]   = 1'b0;
        oe[PIN_SCK]   = 1'b0;
        oe[PIN_SDO]   = 1'b0;
        dout[PIN_SDI] = miso_out;
      end
      default: ;
    endcase
  end

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_pue
      assign pue[i] = ~oe[i] & out_q[i] & ~pud;
    end
  endgenerate
endmodule

// File: rtl/gpio_spi_port.sv
module gpio_spi_port
  import gpio_spi_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                dir_we,
  input  logic [WIDTH-1:0]    dir_wdata,
  input  logic                out_we,
  input  logic [WIDTH-1:0]    out_wdata,
  input  logic                pud,
  input  logic                spi_en,
  input  logic                spi_master,
  input  logic                spi_mosi_out,
  input  logic                spi_miso_out,
  input  logic                spi_sck_out,
  input  logic [NUM_OC-1:0]   oc_en,
  input  logic [NUM_OC-1:0]   oc_val,
  input  logic [WIDTH-1:0]    pad_in,
  output logic [WIDTH-1:0]    pad_oe,
  output logic [WIDTH-1:0]    pad_do,
  output logic [WIDTH-1:0]    pad_pue,
  output logic [WIDTH-1:0]    pin_val,
  output logic                spi_sdi,
  output logic                spi_sck_in,
  output logic                spi_ss_n
);
  logic [WIDTH-1:0] dir_q, out_q;
  logic [WIDTH-1:0] oe_n, do_n, pue_n;
  spi_mode_e        mode;

  assign mode = decode_mode(spi_en, spi_master);

  port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst(rst),
    .dir_we(dir_we), .dir_wdata(dir_wdata),
    .out_we(out_we), .out_wdata(out_wdata),
    .dir_q(dir_q), .out_q(out_q)
  );

  pin_override #(.WIDTH(WIDTH)) u_ovr (
    .mode(mode), .dir_q(dir_q), .out_q(out_q), .pud(pud),
    .mosi_out(spi_mosi_out), .miso_out(spi_miso_out), .sck_out(spi_sck_out),
    .oc_en(oc_en), .oc_val(oc_val),
    .oe(oe_n), .dout(do_n), .pue(pue_n)
  );

  pad_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(pin_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_oe  <= '0;
      pad_do  <= '0;
      pad_pue <= '0;
    end else begin
      pad_oe  <= oe_n;
      pad_do  <= do_n;
      pad_pue <= pue_n;
    end
  end

  assign spi_sdi    = (mode == MODE_MASTER) ? pin_val[PIN_SDI] : pin_val[PIN_SDO];
  assign spi_sck_in = pin_val[PIN_SCK];
  assign spi_ss_n   = (mode == MODE_SLAVE) ? pin_val[PIN_SEL] : 1'b1;
endmodule

// File: rtl/gpio_spi_port_chk.sv
module gpio_spi_port_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             pud,
  input logic             spi_en,
  input logic             spi_master,
  input logic [WIDTH-1:0] pad_in,
  input logic [WIDTH-1:0] pad_oe,
  input logic [WIDTH-1:0] pad_pue,
  input logic [WIDTH-1:0] pin_val
);
  a_r2_master_sdi_input: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(spi_en) && $past(spi_master)) |-> !pad_oe[3]);

  a_r3_slave_pins_input: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(spi_en) && !$past(spi_master)) |-> (pad_oe[2:0] == 3'b000));

  a_r4_pullup_only_input: assert property (@(posedge clk) disable iff (rst)
    (pad_pue & pad_oe) == '0);

  a_r5_pud_blocks_pullup: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pud)) |-> (pad_pue == '0));

  a_r7_sync_depth: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (pin_val == $past(pad_in, 2)));

  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (pad_oe == '0 && pad_pue == '0 && pin_val == '0));
endmodule

bind gpio_spi_port gpio_spi_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .pud(pud), .spi_en(spi_en), .spi_master(spi_master),
  .pad_in(pad_in), .pad_oe(pad_oe), .pad_pue(pad_pue), .pin_val(pin_val)
);

// File: tb/sim_gpio_spi_port.sv
module sim_gpio_spi_port;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dir_we = 0, out_we = 0;
  logic [7:0] dir_wdata = 0, out_wdata = 0;
  logic pud = 0, spi_en = 0, spi_master = 0;
  logic spi_mosi_out = 0, spi_miso_out = 0, spi_sck_out = 0;
  logic [2:0] oc_en = 0, oc_val = 0;
  logic [7:0] pad_in = 0;
  logic [7:0] pad_oe, pad_do, pad_pue, pin_val;
  logic spi_sdi, spi_sck_in, spi_ss_n;

  int tests = 0, fails = 0;
  logic [7:0] dir_m = 0, out_m = 0;

  always #10 clk = ~clk;

  gpio_spi_port u0 (
    .clk(clk), .rst(rst), .dir_we(dir_we), .dir_wdata(dir_wdata),
    .out_we(out_we), .out_wdata(out_wdata), .pud(pud),
    .spi_en(spi_en), .spi_master(spi_master), .spi_mosi_out(spi_mosi_out),
    .spi_miso_out(spi_miso_out), .spi_sck_out(spi_sck_out),
    .oc_en(oc_en), .oc_val(oc_val), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_do(pad_do), .pad_pue(pad_pue), .pin_val(pin_val),
    .spi_sdi(spi_sdi), .spi_sck_in(spi_sck_in), .spi_ss_n(spi_ss_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] m_oe();
    logic [7:0] r = dir_m;
    if (spi_en && spi_master) r[3] = 1'b0;
    if (spi_en && !spi_master) r[2:0] = 3'b000;
    return r;
  endfunction

  function automatic logic [7:0] m_do();
    logic [7:0] r = out_m;
    for (int k = 0; k < 3; k++) if (oc_en[k]) r[4+k] = oc_val[k];
    if (spi_en && spi_master) begin r[2] = spi_mosi_out; r[1] = spi_sck_out; end
    if (spi_en && !spi_master) r[3] = spi_miso_out;
    return r;
  endfunction

  function automatic logic [7:0] m_pue();
    return pud ? 8'h00 : (~m_oe() & out_m);
  endfunction

  task automatic write_regs(input logic [7:0] d, input logic [7:0] o);
    @(negedge clk);
    dir_we = 1; dir_wdata = d; out_we = 1; out_wdata = o;
    dir_m = d; out_m = o;
    @(negedge clk);
    dir_we = 0; out_we = 0;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_pads(input string req);
    check({req, " oe"}, pad_oe, m_oe());
    check({req, " do"}, pad_do, m_do());
    check({req, " pue"}, pad_pue, m_pue());
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R10 oe", pad_oe, 8'h00);
    check("R10 do", pad_do, 8'h00);
    check("R10 pue", pad_pue, 8'h00);
    check("R10 pin", pin_val, 8'h00);
  endtask

  task automatic t_gpio();
    spi_en = 0;
    write_regs(8'hA5, 8'h3C); settle(); check_pads("R1 gpio a");
    write_regs(8'h5A, 8'hC3); settle(); check_pads("R1 gpio b");
  endtask

  task automatic t_master();
    spi_en = 1; spi_master = 1; spi_mosi_out = 1; spi_sck_out = 0;
    write_regs(8'hFF, 8'h00); settle(); check_pads("R2 master all out");
    check("R2 pin3 forced input", pad_oe[3], 1'b0);
    spi_mosi_out = 0; spi_sck_out = 1;
    write_regs(8'h07, 8'h01); settle(); check_pads("R2 master b");
  endtask

  task automatic t_slave();
    spi_en = 1; spi_master = 0; spi_miso_out = 1;
    write_regs(8'hFF, 8'h00); settle(); check_pads("R3 slave all out");
    check("R3 pins0-2 input", pad_oe[2:0], 3'b000);
    spi_miso_out = 0;
    write_regs(8'h08, 8'h00); settle(); check_pads("R3 slave b");
  endtask

  task automatic t_pullup();
    pud = 0;
    spi_en = 1; spi_master = 0;
    write_regs(8'h0F, 8'hFF); settle(); check_pads("R4 slave pullups");
    check("R4 forced pins pulled", pad_pue[2:0], 3'b111);
    spi_master = 1; settle(); check_pads("R4 master pullups");
    check("R4 pin3 pulled", pad_pue[3], 1'b1);
  endtask

  task automatic t_pud();
    pud = 1; settle();
    check("R5 pud", pad_pue, 8'h00);
    check_pads("R5 pads");
    pud = 0;
  endtask

  task automatic t_compare();
    spi_en = 0; oc_en = 3'b101; oc_val = 3'b111;
    write_regs(8'h70, 8'h00); settle(); check_pads("R6 compare");
    check("R6 pin5 port", pad_do[5], 1'b0);
    oc_en = 3'b111; oc_val = 3'b010;
    write_regs(8'h00, 8'h70); settle(); check_pads("R6 compare inputs");
    oc_en = 0;
  endtask

  task automatic t_sync();
    @(negedge clk); pad_in = 8'h00; settle();
    @(negedge clk); pad_in = 8'hA5;
    @(posedge clk); @(negedge clk);
    check("R7 one edge old", pin_val, 8'h00);
    @(posedge clk); @(negedge clk);
    check("R7 two edges new", pin_val, 8'hA5);
  endtask

  task automatic t_spi_in();
    spi_en = 1; spi_master = 1; pad_in = 8'b0000_1010; settle();
    check("R8 master sdi", spi_sdi, 1'b1);
    check("R8 sck in", spi_sck_in, 1'b1);
    check("R9 master ss_n", spi_ss_n, 1'b1);
    spi_master = 0; settle();
    check("R8 slave sdi", spi_sdi, 1'b0);
    check("R9 slave ss low", spi_ss_n, 1'b0);
    pad_in = 8'b0000_0101; settle();
    check("R8 slave sdi b", spi_sdi, 1'b1);
    check("R9 slave ss high", spi_ss_n, 1'b1);
    spi_en = 0; settle();
    check("R9 gpio ss_n", spi_ss_n, 1'b1);
  endtask

  task automatic t_latency();
    spi_en = 0;
    write_regs(8'h00, 8'h00); settle();
    @(negedge clk); dir_we = 1; dir_wdata = 8'hFF; dir_m = 8'hFF;
    @(posedge clk); @(negedge clk); dir_we = 0;
    check("R11 one edge old", pad_oe, 8'h00);
    @(posedge clk); @(negedge clk);
    check("R11 two edges new", pad_oe, 8'hFF);
    spi_en = 1; spi_master = 0;
    @(posedge clk); @(negedge clk);
    check("R11 mode one edge", pad_oe, 8'hF8);
  endtask

  bit done = 0;
  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset();
    t_gpio();
    t_master();
    t_slave();
    t_pullup();
    t_pud();
    t_compare();
    t_sync();
    t_spi_in();
    t_latency();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule